// File: doc/BRIEF.md
# Wake Event Status Register

This block collects power-management wake and event sources into one status byte. Each live bit is sticky. Hardware sets it when its source fires, and software clears it by writing a 1 into that bit position. The sources are:

- an audio codec, detected either as a data-in line held high while the codec bit clock has stopped, or as a wake-interrupt flag from the codec controller;
- two USB controllers;
- a thermal pin with selectable polarity;
- a thermal-override pulse that reports clock throttling.

From the status bits and the per-source enables, the block drives a level wake request and a level power-management event request. A plain read/write port gives software the status byte. The codec bit belongs to the deepest reset domain, so it survives an ordinary hard reset. All other state is cleared by either reset.

The bit clock, the codec data-in lines and the thermal pin are asynchronous, so each passes through a two-flop synchronizer. The bit clock counts as stopped after a parameterised number of system-clock cycles with no edge. Both resets are asserted asynchronously and released synchronously.

Top module: `pm_wake_status`

## Requirements
- R1: The read byte places the thermal status at bit 0, the override status at bit 1, USB controller 1 at bit 3, USB controller 2 at bit 4 and the codec status at bit 5. Bit 2 and bits 7:6 always read 0 and ignore writes.
- R2: A write clears exactly the status bits whose write-data bit is 1. Bits written with 0 keep their value.
- R3: When a set event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R4: The codec bit sets when either codec data-in line is high and no bit-clock edge has been seen for STALL_CYCLES system clocks. It does not set while the bit clock keeps toggling.
- R5: A one-cycle codec wake-interrupt flag sets the codec bit in the next cycle.
- R6: Reset state is an all-zero status byte with both requests low. Pulsing rst_n alone clears every bit except the codec bit. Only rst_deep_n clears the codec bit.
- R7: A one-cycle USB request sets its status bit in the next cycle. That bit adds to wake_req only when its enable (usb_wake_en bit 0 for controller 1, bit 1 for controller 2) is 1.
- R8: The override pulse sets bit 1, and bit 1 never raises wake_req or pme_req.
- R9: The thermal bit sets once when the synchronized pin becomes active (therm_pol=1: high is active; 0: low is active). Clearing it while the pin stays active leaves it clear.
- R10: pme_req is high exactly while the thermal bit is set and therm_en is 1.
- R11: wake_req stays high for as long as the codec bit, or any enabled USB bit, remains set. The codec bit needs no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hard reset, active low; the codec bit is kept |
| rst_deep_n | input | 1 | Deepest-domain reset, active low; clears everything |
| codec_din | input | 2 | Codec data-in lines, asynchronous |
| codec_bclk | input | 1 | Codec bit clock, asynchronous |
| codec_wake_irq | input | 1 | Codec controller wake-interrupt flag |
| usb_wake_req | input | 2 | Wake requests from USB controllers 1 and 2 |
| usb_wake_en | input | 2 | Wake enables for USB controllers 1 and 2 |
| therm_pin | input | 1 | Thermal pin, asynchronous |
| therm_pol | input | 1 | Thermal pin polarity, 1 = active high |
| therm_en | input | 1 | Thermal event enable |
| therm_ovr_pulse | input | 1 | Thermal-override throttling start pulse |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 8 | Write data; a 1 clears that bit |
| reg_rdata | output | 8 | Status byte |
| wake_req | output | 1 | Wake-event request |
| pme_req | output | 1 | Power-management event request |

## Verification
USB, override and wake-interrupt pulses are driven for one cycle and show up in the status byte one edge later. A write clears on the edge that ends its strobe. The requests follow the status byte in the same cycle, so the bench samples on the falling edge after the strobe.

The thermal pin needs three edges: two for the synchronizer and one for the status flop. The bench waits four cycles after it changes the pin.

The codec stall path adds the counter window to the synchronizer delay and is due STALL_CYCLES+4 edges after the last bit-clock change. Because the toggler may stop one cycle late, the bench checks that the bit is still clear at STALL_CYCLES cycles and that it is set at STALL_CYCLES+6 cycles, which keeps both checks clear of that boundary.

// File: rtl/pmw_pkg.sv
package pmw_pkg;
  localparam int STAT_W    = 8;
  localparam int NUM_USB   = 2;
  localparam int B_THERM   = 0;
  localparam int B_OVR     = 1;
  localparam int B_RSVD    = 2;
  localparam int B_USB_LO  = 3;
  localparam int B_CODEC   = B_USB_LO + NUM_USB;
  localparam int LIVE_TOP  = B_CODEC;
endpackage

// File: rtl/pmw_sync.sv
module pmw_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign d_sync = sync_q;
endmodule

// File: rtl/pmw_bclk_watch.sv
module pmw_bclk_watch #(
  parameter int STALL_CYCLES = 16,
  localparam int CNT_W = $clog2(STALL_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_s,
  output logic stalled
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(STALL_CYCLES);

  logic             bclk_d_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             edge_seen;
  logic             at_limit;

  assign edge_seen = bclk_s ^ bclk_d_q;
  assign at_limit  = (cnt_q == LIMIT);

  always_comb begin
    cnt_d = cnt_q;
    if (edge_seen) begin
      cnt_d = '0;
    end else if (!at_limit) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      bclk_d_q <= bclk_s;
      cnt_q    <= cnt_d;
    end
  end

  assign stalled = at_limit;
endmodule

// File: rtl/pmw_w1c_bit.sv
module pmw_w1c_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  output logic q
);
  logic q_r;
  logic q_d;

  always_comb begin
    q_d = q_r;
    if (clr_ev) q_d = 1'b0;
    if (set_ev) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/pm_wake_status.sv
module pm_wake_status
  import pmw_pkg::*;
#(
  parameter int STALL_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_deep_n,
  input  logic [1:0]        codec_din,
  input  logic              codec_bclk,
  input  logic              codec_wake_irq,
  input  logic [NUM_USB-1:0] usb_wake_req,
  input  logic [NUM_USB-1:0] usb_wake_en,
  input  logic              therm_pin,
  input  logic              therm_pol,
  input  logic              therm_en,
  input  logic              therm_ovr_pulse,
  input  logic              reg_wr,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] reg_rdata,
  output logic              wake_req,
  output logic              pme_req
);
  // reset conditioning: asynchronous assert, synchronous release
  logic       rst_core_raw_n;
  logic [1:0] rst_deep_q;
  logic [1:0] rst_core_q;
  logic       rst_deep_s;
  logic       rst_core_s;

  assign rst_core_raw_n = rst_n & rst_deep_n;

  always_ff @(posedge clk or negedge rst_deep_n) begin
    if (!rst_deep_n) rst_deep_q <= 2'b00;
    else             rst_deep_q <= {rst_deep_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_core_raw_n) begin
    if (!rst_core_raw_n) rst_core_q <= 2'b00;
    else                 rst_core_q <= {rst_core_q[0], 1'b1};
  end

  assign rst_deep_s = rst_deep_q[1];
  assign rst_core_s = rst_core_q[1];

  // synchronizers for asynchronous pins
  logic [3:0] async_in;
  logic [3:0] async_s;
  logic [1:0] din_s;
  logic       bclk_s;
  logic       therm_s;

  assign async_in = {therm_pin, codec_bclk, codec_din};

  pmw_sync #(.W(4)) u_sync (
    .clk    (clk),
    .rst_n  (rst_core_s),
    .d_async(async_in),
    .d_sync (async_s)
  );

  assign din_s   = async_s[1:0];
  assign bclk_s  = async_s[2];
  assign therm_s = async_s[3];

  // codec bit clock stall detector
  logic bclk_stalled;

  pmw_bclk_watch #(.STALL_CYCLES(STALL_CYCLES)) u_bclk (
    .clk    (clk),
    .rst_n  (rst_core_s),
    .bclk_s (bclk_s),
    .stalled(bclk_stalled)
  );

  // thermal activation edge
  logic therm_act;
  logic therm_act_q;
  logic therm_rise;

  assign therm_act  = therm_pol ? therm_s : ~therm_s;
  assign therm_rise = therm_act & ~therm_act_q;

  always_ff @(posedge clk or negedge rst_core_s) begin
    if (!rst_core_s) therm_act_q <= 1'b1;
    else             therm_act_q <= therm_act;
  end

  // per-bit set and clear vectors
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] stat;

  always_comb begin
    set_vec                               = '0;
    set_vec[B_THERM]                      = therm_rise;
    set_vec[B_OVR]                        = therm_ovr_pulse;
    set_vec[B_USB_LO +: NUM_USB]          = usb_wake_req;
    set_vec[B_CODEC]                      = ((|din_s) & bclk_stalled) | codec_wake_irq;
  end

  assign clr_vec = reg_wr ? reg_wdata : '0;

  for (genvar i = 0; i < STAT_W; i++) begin : g_stat
    if (i == B_RSVD || i > LIVE_TOP) begin : g_zero
      assign stat[i] = 1'b0;
    end else begin : g_live
      logic bit_rst_n;
      assign bit_rst_n = (i == B_CODEC) ? rst_deep_s : rst_core_s;
      pmw_w1c_bit u_bit (
        .clk   (clk),
        .rst_n (bit_rst_n),
        .set_ev(set_vec[i]),
        .clr_ev(clr_vec[i]),
        .q     (stat[i])
      );
    end
  end

  // request outputs
  assign reg_rdata = stat;
  assign wake_req  = stat[B_CODEC] | (|(stat[B_USB_LO +: NUM_USB] & usb_wake_en));
  assign pme_req   = stat[B_THERM] & therm_en;
endmodule

// File: rtl/pm_wake_status_chk.sv
module pm_wake_status_chk (
  input logic       clk,
  input logic       rst_core_s,
  input logic       reg_wr,
  input logic [7:0] reg_rdata,
  input logic [1:0] usb_wake_req,
  input logic       therm_en,
  input logic       therm_ovr_pulse,
  input logic       wake_req,
  input logic       pme_req
);
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_core_s)
    (reg_rdata[2] == 1'b0) && (reg_rdata[7:6] == 2'b00));

  a_r2_no_write_holds: assert property (@(posedge clk) disable iff (!rst_core_s)
    !reg_wr |=> ((reg_rdata & $past(reg_rdata)) == $past(reg_rdata)));

  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_core_s)
    usb_wake_req[0] |=> reg_rdata[3]);

  a_r7_usb2_sets: assert property (@(posedge clk) disable iff (!rst_core_s)
    usb_wake_req[1] |=> reg_rdata[4]);

  a_r8_ovr_sets: assert property (@(posedge clk) disable iff (!rst_core_s)
    therm_ovr_pulse |=> reg_rdata[1]);

  a_r8_ovr_no_wake: assert property (@(posedge clk) disable iff (!rst_core_s)
    (reg_rdata[5:3] == 3'b000) |-> !wake_req);

  a_r10_pme_source: assert property (@(posedge clk) disable iff (!rst_core_s)
    pme_req |-> (therm_en && reg_rdata[0]));

  a_r11_codec_wakes: assert property (@(posedge clk) disable iff (!rst_core_s)
    reg_rdata[5] |-> wake_req);
endmodule

bind pm_wake_status pm_wake_status_chk u_chk (
  .clk            (clk),
  .rst_core_s     (rst_core_s),
  .reg_wr         (reg_wr),
  .reg_rdata      (reg_rdata),
  .usb_wake_req   (usb_wake_req),
  .therm_en       (therm_en),
  .therm_ovr_pulse(therm_ovr_pulse),
  .wake_req       (wake_req),
  .pme_req        (pme_req)
);

// File: tb/pm_wake_status_tb.sv
`timescale 1ns/1ps
module pm_wake_status_tb;
  localparam int STALL = 16;

  logic       clk = 1'b0;
  logic       rst_n, rst_deep_n;
  logic [1:0] codec_din;
  logic       codec_bclk, codec_wake_irq;
  logic [1:0] usb_wake_req, usb_wake_en;
  logic       therm_pin, therm_pol, therm_en, therm_ovr_pulse;
  logic       reg_wr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       wake_req, pme_req;
  logic       bclk_run;
  int         n_chk = 0;
  int         n_fail = 0;

  always #2 clk = ~clk;

  pm_wake_status #(.STALL_CYCLES(STALL)) u_dut (
    .clk(clk), .rst_n(rst_n), .rst_deep_n(rst_deep_n),
    .codec_din(codec_din), .codec_bclk(codec_bclk), .codec_wake_irq(codec_wake_irq),
    .usb_wake_req(usb_wake_req), .usb_wake_en(usb_wake_en),
    .therm_pin(therm_pin), .therm_pol(therm_pol), .therm_en(therm_en),
    .therm_ovr_pulse(therm_ovr_pulse),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wake_req(wake_req), .pme_req(pme_req)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    cyc(1);
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic pulse_usb(input logic [1:0] m);
    usb_wake_req = m;
    cyc(1);
    usb_wake_req = 2'b00;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (bclk_run) codec_bclk = ~codec_bclk;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst_n = 1'b0; rst_deep_n = 1'b0; codec_din = 2'b00; codec_bclk = 1'b0;
    codec_wake_irq = 1'b0; usb_wake_req = 2'b00; usb_wake_en = 2'b00;
    therm_pin = 1'b0; therm_pol = 1'b1; therm_en = 1'b0; therm_ovr_pulse = 1'b0;
    reg_wr = 1'b0; reg_wdata = 8'h00; bclk_run = 1'b0;
    cyc(3);
    rst_n = 1'b1; rst_deep_n = 1'b1;
    cyc(4);
    chk("R6 reset status", reg_rdata, 8'h00);
    chk("R6 reset requests", {6'b0, wake_req, pme_req}, 8'h00);

    wr(8'hFF);
    chk("R1 write ones on empty byte", reg_rdata, 8'h00);

    // USB sweep over every enable and request pattern
    for (int en = 0; en < 4; en++) begin
      for (int m = 1; m < 4; m++) begin
        usb_wake_en = 2'(en);
        pulse_usb(2'(m));
        chk("R7 usb status bits", reg_rdata, 8'(m << 3));
        chk("R11 usb wake gating", {7'b0, wake_req}, {7'b0, |(en[1:0] & m[1:0])});
        wr(8'h00);
        chk("R2 zero write keeps", reg_rdata, 8'(m << 3));
        cyc(3);
        chk("R11 wake held while set", {7'b0, wake_req}, {7'b0, |(en[1:0] & m[1:0])});
        wr(8'h08);
        chk("R2 selective clear", reg_rdata, 8'(m << 3) & 8'h10);
        wr(8'h10);
        chk("R2 full clear", reg_rdata, 8'h00);
      end
    end

    // set versus clear in the same cycle
    usb_wake_req = 2'b01; reg_wr = 1'b1; reg_wdata = 8'h08;
    cyc(1);
    usb_wake_req = 2'b00; reg_wr = 1'b0; reg_wdata = 8'h00;
    chk("R3 set wins over clear", reg_rdata, 8'h08);
    wr(8'h08);

    // override pulse raises no request
    usb_wake_en = 2'b11; therm_en = 1'b1;
    therm_ovr_pulse = 1'b1; cyc(1); therm_ovr_pulse = 1'b0;
    chk("R8 override status", reg_rdata, 8'h02);
    chk("R8 override no requests", {6'b0, wake_req, pme_req}, 8'h00);
    wr(8'hFB);
    chk("R1 reserved still zero", reg_rdata, 8'h00);

    // thermal, active high
    therm_pin = 1'b1;
    cyc(1);
    chk("R9 not yet synchronized", reg_rdata, 8'h00);
    cyc(3);
    chk("R9 active-high set", reg_rdata, 8'h01);
    chk("R10 pme with enable", {7'b0, pme_req}, 8'h01);
    therm_en = 1'b0; cyc(1);
    chk("R10 pme masked", {7'b0, pme_req}, 8'h00);
    therm_en = 1'b1;
    wr(8'h01); cyc(3);
    chk("R9 sets once while held", reg_rdata, 8'h00);
    therm_pol = 1'b0; cyc(3);
    chk("R9 inactive under low polarity", reg_rdata, 8'h00);
    therm_pin = 1'b0; cyc(4);
    chk("R9 active-low set", reg_rdata, 8'h01);
    wr(8'h01);
    therm_pol = 1'b1; cyc(3);
    chk("R9 polarity swap to inactive", reg_rdata, 8'h00);

    // codec wake interrupt and reset domains
    usb_wake_en = 2'b00;
    codec_wake_irq = 1'b1; cyc(1); codec_wake_irq = 1'b0;
    chk("R5 codec irq sets", reg_rdata, 8'h20);
    chk("R11 codec wake without enable", {7'b0, wake_req}, 8'h01);
    pulse_usb(2'b01);
    ovr_and_reset();
    chk("R6 codec survives hard reset", reg_rdata, 8'h20);
    rst_deep_n = 1'b0; cyc(2); rst_deep_n = 1'b1; cyc(4);
    chk("R6 deep reset clears codec", reg_rdata, 8'h00);

    // codec bit-clock stall detection
    bclk_run = 1'b1; cyc(4);
    codec_din = 2'b10; cyc(40);
    chk("R4 toggling clock no set", reg_rdata, 8'h00);
    bclk_run = 1'b0;
    cyc(STALL);
    chk("R4 before stall window", reg_rdata, 8'h00);
    cyc(6);
    chk("R4 stalled with data high", reg_rdata, 8'h20);
    codec_din = 2'b00; cyc(3);
    wr(8'h20);
    chk("R4 no set with data low", reg_rdata, 8'h00);
    codec_din = 2'b01; cyc(4);
    chk("R4 other data line", reg_rdata, 8'h20);
    codec_din = 2'b00; cyc(3);
    wr(8'h20);
    chk("R2 codec clear", reg_rdata, 8'h00);

    report();
  end

  task automatic ovr_and_reset;
    chk("R6 status before hard reset", reg_rdata, 8'h28);
    rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(4);
  endtask
endmodule